// File: doc/BRIEF.md
# Indirect Memory and Peripheral Access Window

This block sits behind a host register bus and lets the host reach two internal spaces that are not directly mapped: a word-wide SRAM and a peripheral register bus. Every transfer takes two steps. The host first loads an address register, then reads or writes the matching data register, and the block turns that data access into an internal SRAM or peripheral cycle.

The SRAM path keeps separate read and write pointers. Each data access moves its own pointer on by one 32-bit word, so a block of consecutive words moves with a single address load. The peripheral path also keeps separate read and write address registers. Each one holds a 16-bit register offset and a 2-bit transfer size, which sets the byte-write strobes or masks off the unused read bytes. Peripheral addresses stay fixed across repeated accesses.

SRAM reads take one wait state, because the SRAM returns data a cycle after the request. All other host accesses complete in the cycle they are presented.

Top module: `ind_access_win`

## Requirements
- R1: After reset, all four address registers read back zero, `hst_ready` is high, and no SRAM or peripheral strobe is active while the host is idle.
- R2: The window is based at host offset 0x400. The memory read pointer is at 0x40C, the memory write pointer at 0x410, the peripheral write address at 0x444 and the peripheral read address at 0x448. Each reads back its current value. In the peripheral address registers, only bits 15:0 (offset) and bits 25:24 (size) are stored, and all other bits read zero.
- R3: A host write to 0x418 drives one SRAM write at the write pointer with the host data. The write pointer then advances by 4.
- R4: A host read of 0x41C asserts `mem_re` at the read pointer and holds `hst_ready` low for exactly one cycle. In the next cycle it returns the SRAM data with `hst_ready` high. The read pointer then advances by 4.
- R5: The memory read and write pointers are independent: advancing or loading one leaves the other unchanged.
- R6: A host write to 0x44C drives one peripheral write at the stored offset with the host data. The byte strobes are 0001, 0011, 0111 or 1111 for size values 0 to 3.
- R7: A host read of 0x450 drives a peripheral read at the stored offset with no wait state. It returns the peripheral data with bytes above size+1 forced to zero.
- R8: Peripheral address registers do not change on peripheral data accesses.
- R9: Host accesses to offsets outside the eight registers cause no internal access and change no state. Reads of them, and reads of the write-data registers 0x418 and 0x44C, return zero.
- R10: Memory pointers wrap from 0xFFFFFFFC to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 12 | Host register byte address |
| hst_wdata | input | 32 | Host write data |
| hst_we | input | 1 | Host write enable, held until `hst_ready` |
| hst_re | input | 1 | Host read enable, held until `hst_ready` |
| hst_rdata | output | 32 | Host read data, valid when `hst_ready` |
| hst_ready | output | 1 | Access completes this cycle |
| mem_addr | output | 32 | SRAM byte address |
| mem_we | output | 1 | SRAM write strobe |
| mem_re | output | 1 | SRAM read request (data next cycle) |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after `mem_re` |
| per_addr | output | 16 | Peripheral register offset |
| per_we | output | 1 | Peripheral write strobe |
| per_re | output | 1 | Peripheral read strobe |
| per_wstrb | output | 4 | Peripheral byte write strobes |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, same cycle as `per_re` |

## Verification
The assertions assume a well-behaved host. It never raises `hst_we` and `hst_re` together. It holds a read request, unchanged, until `hst_ready` goes high. It returns SRAM data exactly one cycle after `mem_re`. Under those assumptions the wait state is a single cycle, and the returned word is the one the SRAM delivered. The bench keeps within these rules by driving every access through one write task or one read task. Both tasks change inputs on the falling edge and drop the enable right after the completing edge. The bench's SRAM model registers its read data on the edge that sees `mem_re`.

// File: rtl/iaw_pkg.sv
package iaw_pkg;

  localparam int DW    = 32;
  localparam int NBYTE = DW / 8;

  // Register offsets relative to the window base; the host software map depends on them.
  localparam logic [11:0] OFS_MEM_RPTR = 12'h00C;
  localparam logic [11:0] OFS_MEM_WPTR = 12'h010;
  localparam logic [11:0] OFS_MEM_WDAT = 12'h018;
  localparam logic [11:0] OFS_MEM_RDAT = 12'h01C;
  localparam logic [11:0] OFS_PER_WADR = 12'h044;
  localparam logic [11:0] OFS_PER_RADR = 12'h048;
  localparam logic [11:0] OFS_PER_WDAT = 12'h04C;
  localparam logic [11:0] OFS_PER_RDAT = 12'h050;

  // Position of the transfer-size field in a peripheral address word.
  localparam int SZ_LSB = 24;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_MEM_RPTR,
    SEL_MEM_WPTR,
    SEL_MEM_WDAT,
    SEL_MEM_RDAT,
    SEL_PER_WADR,
    SEL_PER_RADR,
    SEL_PER_WDAT,
    SEL_PER_RDAT
  } win_sel_e;

  // Contiguous low-byte enable for a (bytes - 1) size code.
  function automatic logic [NBYTE-1:0] size_to_bytes(input logic [1:0] sz);
    logic [NBYTE-1:0] m;
    for (int b = 0; b < NBYTE; b++) m[b] = (b <= int'(sz));
    return m;
  endfunction

endpackage

// File: rtl/iaw_decode.sv
module iaw_decode
  import iaw_pkg::*;
#(
  parameter int          HAW   = 12,
  parameter logic [11:0] HBASE = 12'h400
) (
  input  logic [HAW-1:0] addr,
  output win_sel_e       sel
);

  logic [HAW-1:0] ofs;

  always_comb begin
    ofs = addr - HAW'(HBASE);
    case (ofs)
      HAW'(OFS_MEM_RPTR): sel = SEL_MEM_RPTR;
      HAW'(OFS_MEM_WPTR): sel = SEL_MEM_WPTR;
      HAW'(OFS_MEM_WDAT): sel = SEL_MEM_WDAT;
      HAW'(OFS_MEM_RDAT): sel = SEL_MEM_RDAT;
      HAW'(OFS_PER_WADR): sel = SEL_PER_WADR;
      HAW'(OFS_PER_RADR): sel = SEL_PER_RADR;
      HAW'(OFS_PER_WDAT): sel = SEL_PER_WDAT;
      HAW'(OFS_PER_RDAT): sel = SEL_PER_RDAT;
      default:            sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/iaw_mem_path.sv
module iaw_mem_path
  import iaw_pkg::*;
#(
  parameter int MAW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  win_sel_e       sel,
  input  logic           hst_we,
  input  logic           hst_re,
  input  logic [DW-1:0]  hst_wdata,
  output logic [MAW-1:0] rptr_q,
  output logic [MAW-1:0] wptr_q,
  output logic           rd_stall,
  output logic [MAW-1:0] mem_addr,
  output logic           mem_we,
  output logic           mem_re,
  output logic [DW-1:0]  mem_wdata
);

  localparam logic [MAW-1:0] STEP = MAW'(NBYTE);

  logic           pend_q, pend_d;
  logic [MAW-1:0] rptr_d, wptr_d;
  logic           rptr_en, wptr_en;
  logic           rd_first, rd_done, wr_data;

  always_comb begin
    rd_first = hst_re && (sel == SEL_MEM_RDAT) && !pend_q;
    rd_done  = hst_re && (sel == SEL_MEM_RDAT) &&  pend_q;
    wr_data  = hst_we && (sel == SEL_MEM_WDAT);
    pend_d   = rd_first;

    rptr_en = 1'b0;
    rptr_d  = rptr_q;
    if (hst_we && sel == SEL_MEM_RPTR) begin
      rptr_en = 1'b1;
      rptr_d  = hst_wdata[MAW-1:0];
    end else if (rd_done) begin
      rptr_en = 1'b1;
      rptr_d  = rptr_q + STEP;
    end

    wptr_en = 1'b0;
    wptr_d  = wptr_q;
    if (hst_we && sel == SEL_MEM_WPTR) begin
      wptr_en = 1'b1;
      wptr_d  = hst_wdata[MAW-1:0];
    end else if (wr_data) begin
      wptr_en = 1'b1;
      wptr_d  = wptr_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rptr_q <= '0;
      wptr_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (rptr_en) rptr_q <= rptr_d;
      if (wptr_en) wptr_q <= wptr_d;
    end
  end

  assign rd_stall  = rd_first;
  assign mem_re    = rd_first;
  assign mem_we    = wr_data;
  assign mem_addr  = wr_data ? wptr_q : rptr_q;
  assign mem_wdata = hst_wdata;

endmodule

// File: rtl/iaw_per_path.sv
module iaw_per_path
  import iaw_pkg::*;
#(
  parameter int POW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  win_sel_e         sel,
  input  logic             hst_we,
  input  logic             hst_re,
  input  logic [DW-1:0]    hst_wdata,
  output logic [DW-1:0]    wadr_view,
  output logic [DW-1:0]    radr_view,
  output logic [DW-1:0]    rdat_masked,
  output logic [POW-1:0]   per_addr,
  output logic             per_we,
  output logic             per_re,
  output logic [NBYTE-1:0] per_wstrb,
  output logic [DW-1:0]    per_wdata,
  input  logic [DW-1:0]    per_rdata
);

  logic [POW-1:0]   wofs_q, rofs_q, wofs_d, rofs_d;
  logic [1:0]       wsz_q, rsz_q, wsz_d, rsz_d;
  logic             wadr_en, radr_en;
  logic [NBYTE-1:0] rd_bytes;
  logic [DW-1:0]    rd_mask;

  always_comb begin
    wadr_en = hst_we && (sel == SEL_PER_WADR);
    radr_en = hst_we && (sel == SEL_PER_RADR);
    wofs_d  = hst_wdata[POW-1:0];
    rofs_d  = hst_wdata[POW-1:0];
    wsz_d   = hst_wdata[SZ_LSB+1:SZ_LSB];
    rsz_d   = hst_wdata[SZ_LSB+1:SZ_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wofs_q <= '0;
      wsz_q  <= '0;
      rofs_q <= '0;
      rsz_q  <= '0;
    end else begin
      if (wadr_en) begin
        wofs_q <= wofs_d;
        wsz_q  <= wsz_d;
      end
      if (radr_en) begin
        rofs_q <= rofs_d;
        rsz_q  <= rsz_d;
      end
    end
  end

  assign rd_bytes = size_to_bytes(rsz_q);

  for (genvar b = 0; b < NBYTE; b++) begin : g_mask
    assign rd_mask[8*b +: 8] = {8{rd_bytes[b]}};
  end

  always_comb begin
    wadr_view = '0;
    wadr_view[POW-1:0]           = wofs_q;
    wadr_view[SZ_LSB+1:SZ_LSB]   = wsz_q;
    radr_view = '0;
    radr_view[POW-1:0]           = rofs_q;
    radr_view[SZ_LSB+1:SZ_LSB]   = rsz_q;
  end

  assign per_we      = hst_we && (sel == SEL_PER_WDAT);
  assign per_re      = hst_re && (sel == SEL_PER_RDAT);
  assign per_addr    = per_we ? wofs_q : rofs_q;
  assign per_wstrb   = per_we ? size_to_bytes(wsz_q) : '0;
  assign per_wdata   = hst_wdata;
  assign rdat_masked = per_rdata & rd_mask;

endmodule

// File: rtl/ind_access_win.sv
module ind_access_win
  import iaw_pkg::*;
#(
  parameter int          HAW   = 12,
  parameter logic [11:0] HBASE = 12'h400,
  parameter int          MAW   = 32,
  parameter int          POW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HAW-1:0]   hst_addr,
  input  logic [DW-1:0]    hst_wdata,
  input  logic             hst_we,
  input  logic             hst_re,
  output logic [DW-1:0]    hst_rdata,
  output logic             hst_ready,
  output logic [MAW-1:0]   mem_addr,
  output logic             mem_we,
  output logic             mem_re,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [POW-1:0]   per_addr,
  output logic             per_we,
  output logic             per_re,
  output logic [NBYTE-1:0] per_wstrb,
  output logic [DW-1:0]    per_wdata,
  input  logic [DW-1:0]    per_rdata
);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  win_sel_e       sel;
  logic [MAW-1:0] rptr, wptr;
  logic           rd_stall;
  logic [DW-1:0]  wadr_view, radr_view, prd_masked;

  iaw_decode #(.HAW(HAW), .HBASE(HBASE)) i_dec (
    .addr (hst_addr),
    .sel  (sel)
  );

  iaw_mem_path #(.MAW(MAW)) i_mem (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sel       (sel),
    .hst_we    (hst_we),
    .hst_re    (hst_re),
    .hst_wdata (hst_wdata),
    .rptr_q    (rptr),
    .wptr_q    (wptr),
    .rd_stall  (rd_stall),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata)
  );

  iaw_per_path #(.POW(POW)) i_per (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sel         (sel),
    .hst_we      (hst_we),
    .hst_re      (hst_re),
    .hst_wdata   (hst_wdata),
    .wadr_view   (wadr_view),
    .radr_view   (radr_view),
    .rdat_masked (prd_masked),
    .per_addr    (per_addr),
    .per_we      (per_we),
    .per_re      (per_re),
    .per_wstrb   (per_wstrb),
    .per_wdata   (per_wdata),
    .per_rdata   (per_rdata)
  );

  always_comb begin
    case (sel)
      SEL_MEM_RPTR: hst_rdata = DW'(rptr);
      SEL_MEM_WPTR: hst_rdata = DW'(wptr);
      SEL_MEM_RDAT: hst_rdata = mem_rdata;
      SEL_PER_WADR: hst_rdata = wadr_view;
      SEL_PER_RADR: hst_rdata = radr_view;
      SEL_PER_RDAT: hst_rdata = prd_masked;
      default:      hst_rdata = '0;
    endcase
  end

  assign hst_ready = !rd_stall;

endmodule

// File: rtl/iaw_checker.sv
module iaw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hst_we,
  input logic        hst_re,
  input logic        hst_ready,
  input logic [31:0] hst_rdata,
  input logic        mem_we,
  input logic        mem_re,
  input logic [31:0] mem_rdata,
  input logic        per_we,
  input logic        per_re,
  input logic [3:0]  per_wstrb
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_we || hst_re) |-> !(mem_we || mem_re || per_we || per_re));

  a_r4_one_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_re && !hst_ready) |=> hst_ready);

  a_r4_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  a_r4_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_re) && hst_re && hst_ready) |-> (hst_rdata == mem_rdata));

  a_r6_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |-> (per_wstrb inside {4'b0001, 4'b0011, 4'b0111, 4'b1111}));

  a_r7_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    per_re |-> hst_ready);

  a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re, per_we, per_re}));

endmodule

bind ind_access_win iaw_checker i_iaw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hst_we    (hst_we),
  .hst_re    (hst_re),
  .hst_ready (hst_ready),
  .hst_rdata (hst_rdata),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_rdata (mem_rdata),
  .per_we    (per_we),
  .per_re    (per_re),
  .per_wstrb (per_wstrb)
);

// File: tb/test_ind_access_win.sv
`timescale 1ns/1ps
module test_ind_access_win;

  localparam logic [11:0] A_MRP = 12'h40C, A_MWP = 12'h410, A_MWD = 12'h418,
                          A_MRD = 12'h41C, A_PWA = 12'h444, A_PRA = 12'h448,
                          A_PWD = 12'h44C, A_PRD = 12'h450, A_GAP = 12'h414;

  logic        clk, rst_n;
  logic [11:0] hst_addr;
  logic [31:0] hst_wdata, hst_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [31:0] per_wdata, per_rdata;
  logic        hst_we, hst_re, hst_ready, mem_we, mem_re, per_we, per_re;
  logic [15:0] per_addr;
  logic [3:0]  per_wstrb;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  ind_access_win i_ind_access_win (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_we(hst_we), .hst_re(hst_re), .hst_rdata(hst_rdata), .hst_ready(hst_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .per_addr(per_addr), .per_we(per_we), .per_re(per_re),
    .per_wstrb(per_wstrb), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // SRAM model: 16 words, registered read
  logic [31:0] sram [16];
  logic [31:0] rdq;
  int mem_acc = 0, per_acc = 0;
  logic [15:0] last_pa;
  logic [3:0]  last_ps;
  logic [31:0] last_pd;

  initial for (int i = 0; i < 16; i++) sram[i] = 32'h5500_0000 + i;
  initial rdq = '0;
  assign mem_rdata = rdq;
  assign per_rdata = {per_addr, ~per_addr};

  always @(posedge clk) begin
    if (mem_re) rdq <= sram[mem_addr[5:2]];
    if (mem_we) sram[mem_addr[5:2]] <= mem_wdata;
    if (mem_we || mem_re) mem_acc <= mem_acc + 1;
    if (per_we || per_re) per_acc <= per_acc + 1;
    if (per_we) begin
      last_pa <= per_addr; last_ps <= per_wstrb; last_pd <= per_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_we = 1;
    @(posedge clk); #1;
    hst_we = 0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d, output int waits);
    @(negedge clk);
    hst_addr = a; hst_re = 1;
    #2;
    waits = 0;
    while (!hst_ready) begin
      waits++;
      @(negedge clk); #2;
    end
    d = hst_rdata;
    @(posedge clk); #1;
    hst_re = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; int w;
    #1;
    check(hst_ready == 1'b1, "R1 ready", 32'(hst_ready), 1);
    check(!(mem_we || mem_re || per_we || per_re), "R1 no strobes",
          {28'd0, mem_we, mem_re, per_we, per_re}, 0);
    hread(A_MRP, d, w); check(d == 0, "R1 rptr", d, 0);
    hread(A_MWP, d, w); check(d == 0, "R1 wptr", d, 0);
    hread(A_PWA, d, w); check(d == 0, "R1 pwadr", d, 0);
    hread(A_PRA, d, w); check(d == 0, "R1 pradr", d, 0);
  endtask

  task automatic t_mem_write;
    logic [31:0] d; int w;
    hwrite(A_MWP, 32'h0000_0010);
    for (int i = 0; i < 3; i++) hwrite(A_MWD, 32'hA000_0001 + i);
    for (int i = 0; i < 3; i++) check(sram[4+i] == 32'hA000_0001 + i, "R3 sram word", sram[4+i], 32'hA000_0001 + i);
    hread(A_MWP, d, w); check(d == 32'h1C, "R3 wptr advanced", d, 32'h1C);
    hread(A_MRP, d, w); check(d == 0, "R5 rptr untouched by writes", d, 0);
    hread(A_MWD, d, w); check(d == 0, "R9 wdat reads zero", d, 0);
  endtask

  task automatic t_mem_read;
    logic [31:0] d; int w;
    hwrite(A_MRP, 32'h0000_0010);
    for (int i = 0; i < 3; i++) begin
      hread(A_MRD, d, w);
      check(d == 32'hA000_0001 + i, "R4 read data", d, 32'hA000_0001 + i);
      check(w == 1, "R4 one wait state", 32'(w), 1);
    end
    hread(A_MRP, d, w); check(d == 32'h1C, "R4 rptr advanced", d, 32'h1C);
    hread(A_MWP, d, w); check(d == 32'h1C, "R5 wptr untouched by reads", d, 32'h1C);
  endtask

  task automatic t_wrap;
    logic [31:0] d; int w;
    hwrite(A_MWP, 32'hFFFF_FFFC);
    hwrite(A_MWD, 32'h1234_ABCD);
    check(sram[15] == 32'h1234_ABCD, "R10 last word written", sram[15], 32'h1234_ABCD);
    hread(A_MWP, d, w); check(d == 0, "R10 wptr wrapped", d, 0);
    hwrite(A_MRP, 32'hFFFF_FFFC);
    hread(A_MRD, d, w); check(d == 32'h1234_ABCD, "R10 read at top", d, 32'h1234_ABCD);
    hread(A_MRP, d, w); check(d == 0, "R10 rptr wrapped", d, 0);
  endtask

  task automatic t_per_write;
    logic [31:0] d; int w;
    hwrite(A_PWA, 32'hFEAB_1234);
    hread(A_PWA, d, w); check(d == 32'h0200_1234, "R2 pwadr fields only", d, 32'h0200_1234);
    hwrite(A_PWD, 32'hAABB_CCDD);
    check(last_pa == 16'h1234, "R6 per addr", 32'(last_pa), 32'h1234);
    check(last_ps == 4'b0111, "R6 strobe size2", 32'(last_ps), 32'h7);
    check(last_pd == 32'hAABB_CCDD, "R6 per data", last_pd, 32'hAABB_CCDD);
    hwrite(A_PWD, 32'h0102_0304);
    check(last_pa == 16'h1234, "R8 per addr fixed", 32'(last_pa), 32'h1234);
    hread(A_PWA, d, w); check(d == 32'h0200_1234, "R8 pwadr unchanged", d, 32'h0200_1234);
    hwrite(A_PWA, 32'h0000_0042);
    hwrite(A_PWD, 32'h0000_0099);
    check(last_ps == 4'b0001, "R6 strobe size0", 32'(last_ps), 32'h1);
    hwrite(A_PWA, 32'h0300_0042);
    hwrite(A_PWD, 32'h0000_0099);
    check(last_ps == 4'b1111, "R6 strobe size3", 32'(last_ps), 32'hF);
  endtask

  task automatic t_per_read;
    logic [31:0] d; int w;
    hwrite(A_PRA, 32'hFC00_5678);
    hread(A_PRA, d, w); check(d == 32'h0000_5678, "R2 pradr fields only", d, 32'h0000_5678);
    hread(A_PRD, d, w); check(d == 32'h0000_0087, "R7 size0 zero fill", d, 32'h87);
    check(w == 0, "R7 no wait", 32'(w), 0);
    hwrite(A_PRA, 32'h0100_5678);
    hread(A_PRD, d, w); check(d == 32'h0000_A987, "R7 size1 zero fill", d, 32'hA987);
    hwrite(A_PRA, 32'h0300_5678);
    hread(A_PRD, d, w); check(d == 32'h5678_A987, "R7 size3 full", d, 32'h5678_A987);
    hread(A_PRA, d, w); check(d == 32'h0300_5678, "R8 pradr unchanged", d, 32'h0300_5678);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; int w, m0, p0;
    m0 = mem_acc; p0 = per_acc;
    hwrite(A_GAP, 32'hFFFF_FFFF);
    hread(A_GAP, d, w); check(d == 0, "R9 unmapped read zero", d, 0);
    hwrite(12'h000, 32'h0000_0040);
    #2;
    check(mem_acc == m0 && per_acc == p0, "R9 no internal access", 32'(mem_acc + per_acc), 32'(m0 + p0));
    hread(A_MRP, d, w); check(d == 0, "R9 rptr unchanged", d, 0);
    hread(A_MWP, d, w); check(d == 0, "R9 wptr unchanged", d, 0);
  endtask

  initial begin
    rst_n = 0; hst_we = 0; hst_re = 0; hst_addr = '0; hst_wdata = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    repeat (4) @(posedge clk);
    t_reset();
    t_mem_write();
    t_mem_read();
    t_wrap();
    t_per_write();
    t_per_read();
    t_unmapped();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule